// File: doc/BRIEF.md
# Bit-serial bus-port memory sequencer

This block is the device-side controller of a byte-wide memory. A host reaches it over one data line using only ordinary bus cycles. The host issues chip-enable, output-enable and write-enable cycles, and each completed cycle carries one bit. A write cycle delivers the level on the data line. A read cycle returns a bit on the same line. Commands are not encoded in any field. The block recognizes them only from the order of read and write cycles.

The three bus controls are synchronized to the system clock, and every finished cycle is turned into one of three events: read, write-0 or write-1. From these events the block decodes several operations:

- the reset sequence (read, write-0, read);
- a 16-bit address, most significant bit first;
- sequential byte reads;
- loading a page buffer that holds up to 32 bytes;
- the sequence that starts the self-timed nonvolatile write (read, write-1, read).

During the nonvolatile write, a busy timer counts system clocks and copies the loaded bytes into an inferred RAM. A write-enable latch guards that write. The latch is held clear while the write-protect input is low.

Top module: `bitport_mem_seq`

## Requirements
- R1: After the synchronous reset input, `idle` is high and `dq_en` is low. A read cycle then returns 1.
- R2: `dq_en` is high only while `ce_n` and `oe_n` are both low. A write bit is the level on `dq_in` when the first of `we_n` or `ce_n` rises.
- R3: A read, write-0, read sequence leaves the idle state (`idle` low). Reads then return 1 until all 16 address bits have been written, with no read between them, most significant bit first.
- R4: After the address is loaded, each group of 8 reads returns one byte, most significant bit first. The byte address then increments, and it rolls over from the last array location to location 0 of the array.
- R5: A write-1 directly after a read byte ends the sequential read, and `idle` goes high.
- R6: After a page load, a read, write-1, read sequence with the write-enable latch set starts the nonvolatile write. While it runs, every read returns 0. When it ends, reads return 1, and every loaded byte is readable at its address.
- R7: Data bytes land at consecutive offsets within the 32-byte page of the loaded address. Past offset 31, loading wraps to offset 0 of the same page, so later bytes overwrite earlier ones.
- R8: The write-enable latch is set only by a reset sequence while `wp_n` is high. It is held clear while `wp_n` is low, so a start sequence then writes nothing. Driving `wp_n` low during a running nonvolatile write does not stop it.
- R9: A page load that ends with a partial byte does not start a nonvolatile write. In a write that does start, page bytes that were not loaded keep their old contents.
- R10: A read followed by two writes, or a write-1 directly after a read during the address load, sends the block to idle (`idle` high).
- R11: An address whose bits above the array width are not all 0 reads as 1s. A nonvolatile write to such an address changes nothing in the array.
- R12: After a page load, the sequence read, read, write-1, read does not start a nonvolatile write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; stands in for power-up |
| ce_n | input | 1 | Bus chip enable, active low, asynchronous |
| oe_n | input | 1 | Bus output enable, active low, asynchronous |
| we_n | input | 1 | Bus write enable, active low, asynchronous |
| wp_n | input | 1 | Write protect, active low; low blocks nonvolatile writes |
| dq_in | input | 1 | Level sampled from the data line |
| dq_out | output | 1 | Bit presented on the data line |
| dq_en | output | 1 | Enable of the data line tri-state driver |
| idle | output | 1 | High when no sequence is active and no write is running |

## Verification
A wrong sequence state shows up at the very next read cycle. The read returns 1 where a data bit was due, or the reverse, or `idle` takes the wrong level within about three clocks of the offending cycle. A corrupted address counter, page offset or commit index stays hidden until a later readback returns the wrong byte. The bench therefore keeps a byte-level model of the array and compares every known location after each write. A write-enable latch in the wrong state is visible at once, because the first read after a start sequence returns 0 only when a write actually started.

// File: rtl/bitport_mem_seq.sv
module bitport_mem_seq #(
  parameter int ADDR_W     = 16,
  parameter int ARRAY_AW   = 8,
  parameter int PAGE_AW    = 5,
  parameter int NVW_CYCLES = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  input  logic wp_n,
  input  logic dq_in,
  output logic dq_out,
  output logic dq_en,
  output logic idle
);
  localparam int PAGE_BYTES = 1 << PAGE_AW;
  localparam int ARRAY_BYTES = 1 << ARRAY_AW;
  localparam int CW  = $clog2(NVW_CYCLES + 1);
  localparam int ACW = $clog2(ADDR_W + 1);

  typedef enum logic [1:0] {EV_NONE, EV_RD, EV_WR0, EV_WR1} ev_t;
  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_LOADED, S_READ, S_DATA} st_t;
  typedef enum logic [1:0] {C_NONE, C_RD, C_WR} cls_t;

  logic [4:0] s1, s2;
  wire ce_s = s2[0];
  wire oe_s = s2[1];
  wire we_s = s2[2];
  wire dq_s = s2[3];
  wire wp_s = s2[4];

  always_ff @(posedge clk)
    if (rst) begin
      s1 <= '1;
      s2 <= '1;
    end else begin
      s1 <= {wp_n, dq_in, we_n, oe_n, ce_n};
      s2 <= s1;
    end

  cls_t cls, cls_q;
  logic wbit;
  ev_t  ev;

  always_comb begin
    cls = C_NONE;
    if (!ce_s && !we_s && oe_s) cls = C_WR;
    else if (!ce_s && !oe_s && we_s) cls = C_RD;
  end

  always_ff @(posedge clk)
    if (rst) begin
      cls_q <= C_NONE;
      wbit  <= 1'b0;
    end else begin
      cls_q <= cls;
      if (cls == C_WR) wbit <= dq_s;
    end

  always_comb begin
    ev = EV_NONE;
    if (cls_q != cls) begin
      if (cls_q == C_RD) ev = EV_RD;
      else if (cls_q == C_WR) ev = wbit ? EV_WR1 : EV_WR0;
    end
  end

  st_t st;
  ev_t h1, h2;
  logic [ACW-1:0] bcnt;
  logic [ADDR_W-1:0] addr;
  logic [7:0] sh;
  logic [7:0] pg [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pv;
  logic [PAGE_AW-1:0] poff;
  logic anyb, wel, busy;
  logic [CW-1:0] nvc;
  logic [7:0] mem [ARRAY_BYTES];

  wire ev_wr = (ev == EV_WR0) || (ev == EV_WR1);
  wire h1_wr = (h1 == EV_WR0) || (h1 == EV_WR1);
  wire ev_bit = (ev == EV_WR1);
  wire in_range = (addr[ADDR_W-1:ARRAY_AW] == '0);
  wire [7:0] rbyte = mem[addr[ARRAY_AW-1:0]];
  wire [PAGE_AW-1:0] cidx = nvc[PAGE_AW-1:0];
  wire commit = busy && (nvc < CW'(PAGE_BYTES)) && pv[cidx] && in_range;

  assign dq_en = ~ce_n & ~oe_n;
  assign idle  = (st == S_IDLE) && !busy;

  always_comb begin
    if (busy) dq_out = 1'b0;
    else if (in_range && (st == S_LOADED || (st == S_READ && h1 == EV_RD)))
      dq_out = rbyte[~bcnt[2:0]];
    else dq_out = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_IDLE;
      h1   <= EV_NONE;
      h2   <= EV_NONE;
      bcnt <= '0;
      addr <= '0;
      sh   <= '0;
      pv   <= '0;
      poff <= '0;
      anyb <= 1'b0;
      wel  <= 1'b0;
      busy <= 1'b0;
      nvc  <= '0;
    end else begin
      if (busy) begin
        st <= S_IDLE;
        h1 <= EV_NONE;
        h2 <= EV_NONE;
        if (nvc == CW'(NVW_CYCLES - 1)) begin
          busy <= 1'b0;
          nvc  <= '0;
          wel  <= 1'b0;
          pv   <= '0;
        end else nvc <= nvc + 1'b1;
      end else if (ev != EV_NONE) begin
        h1 <= ev;
        h2 <= h1;
        if (ev == EV_RD && h1 == EV_WR0 && h2 == EV_RD) begin
          st   <= S_ADDR;
          bcnt <= '0;
          pv   <= '0;
          anyb <= 1'b0;
          wel  <= 1'b1;
          h1   <= EV_NONE;
          h2   <= EV_NONE;
        end else if (ev_wr && h1_wr && h2 == EV_RD) begin
          st  <= S_IDLE;
          wel <= 1'b0;
        end else if (ev == EV_WR1 && h1 == EV_RD && st != S_DATA) begin
          st  <= S_IDLE;
          wel <= 1'b0;
        end else if (st == S_DATA && ev == EV_RD && h1 == EV_WR1 && h2 == EV_RD) begin
          if (wel && anyb && bcnt[2:0] == 3'd0) begin
            busy <= 1'b1;
            nvc  <= '0;
          end else wel <= 1'b0;
          st <= S_IDLE;
          h1 <= EV_NONE;
          h2 <= EV_NONE;
        end else if (st == S_DATA && ev == EV_RD && h1 == EV_RD) begin
          st  <= S_IDLE;
          wel <= 1'b0;
        end else if (!(ev_wr && h1 == EV_RD)) begin
          case (st)
            S_ADDR:
              if (ev_wr) begin
                addr <= {addr[ADDR_W-2:0], ev_bit};
                if (bcnt == ACW'(ADDR_W - 1)) begin
                  st   <= S_LOADED;
                  bcnt <= '0;
                end else bcnt <= bcnt + 1'b1;
              end
            S_LOADED:
              if (ev == EV_RD) begin
                st   <= S_READ;
                bcnt <= ACW'(1);
              end else begin
                st   <= S_DATA;
                sh   <= {7'd0, ev_bit};
                bcnt <= ACW'(1);
                poff <= addr[PAGE_AW-1:0];
              end
            S_READ:
              if (ev == EV_RD) begin
                if (bcnt[2:0] == 3'd7) begin
                  bcnt <= '0;
                  addr[ARRAY_AW-1:0] <= addr[ARRAY_AW-1:0] + 1'b1;
                end else bcnt <= bcnt + 1'b1;
              end
            S_DATA:
              if (ev_wr) begin
                sh <= {sh[6:0], ev_bit};
                if (bcnt[2:0] == 3'd7) begin
                  pg[poff] <= {sh[6:0], ev_bit};
                  pv[poff] <= 1'b1;
                  poff     <= poff + 1'b1;
                  anyb     <= 1'b1;
                  bcnt     <= '0;
                end else bcnt <= bcnt + 1'b1;
              end
            default: ;
          endcase
        end
      end
      if (!wp_s) wel <= 1'b0;
    end
  end

  always_ff @(posedge clk)
    if (commit) mem[{addr[ARRAY_AW-1:PAGE_AW], cidx}] <= pg[cidx];

endmodule

// File: rtl/bitport_mem_seq_chk.sv
module bitport_mem_seq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              wel,
  input logic              wp_s,
  input logic [2:0]        st,
  input logic [ADDR_W-1:0] addr
);
  AST_START_NEEDS_WEL: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wel)); // R6

  AST_BUSY_KEEPS_IDLE: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (st == 3'd0)); // R6

  AST_BUSY_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(addr)); // R6

  AST_WP_HOLDS_WEL: assert property (@(posedge clk) disable iff (rst)
    !wp_s |=> !wel); // R8

  AST_DONE_CLEARS_WEL: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !wel); // R8
endmodule

bind bitport_mem_seq bitport_mem_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .wel(wel), .wp_s(wp_s), .st(st), .addr(addr)
);

// File: tb/test_bitport_mem_seq.sv
module test_bitport_mem_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, wp_n = 1'b1, dq_in = 1'b0;
  logic dq_out, dq_en, idle;

  always #10 clk = ~clk;

  bitport_mem_seq #(.NVW_CYCLES(40)) i_bitport_mem_seq (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .wp_n(wp_n), .dq_in(dq_in), .dq_out(dq_out), .dq_en(dq_en), .idle(idle));

  int ntest = 0, nfail = 0;
  logic last_en, last_wen;
  logic [7:0] mm [256];
  bit kn [256];
  logic [7:0] buf_d [64];
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    ntest++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_bit(input logic b);
    @(negedge clk); dq_in = b; ce_n = 0; oe_n = 1; we_n = 0;
    repeat (3) @(negedge clk);
    last_wen = dq_en;
    if ($urandom % 2) begin we_n = 1; @(negedge clk); ce_n = 1; end
    else begin ce_n = 1; @(negedge clk); we_n = 1; end
    repeat (4) @(negedge clk);
  endtask

  task automatic rd_bit(output logic b);
    @(negedge clk); ce_n = 0; we_n = 1; oe_n = 0;
    repeat (3) @(negedge clk);
    b = dq_out; last_en = dq_en;
    oe_n = 1; ce_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic reset_seq();
    logic b;
    rd_bit(b); wr_bit(1'b0); rd_bit(b);
  endtask

  task automatic load_addr(input logic [15:0] a, input int nbits);
    for (int i = 15; i > 15 - nbits; i--) wr_bit(a[i]);
  endtask

  task automatic read_byte(output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin rd_bit(b); v[i] = b; end
  endtask

  function automatic logic [7:0] exp_byte(input logic [15:0] a);
    if (a[15:8] != 0) return 8'hFF;
    return mm[a[7:0]];
  endfunction

  function automatic bit known(input logic [15:0] a);
    return (a[15:8] != 0) || kn[a[7:0]];
  endfunction

  task automatic apply_page(input logic [15:0] a, input int n);
    for (int i = 0; i < n; i++) begin
      logic [15:0] ad;
      ad = {a[15:5], 5'((a[4:0] + i) % 32)};
      if (ad[15:8] == 0) begin mm[ad[7:0]] = buf_d[i]; kn[ad[7:0]] = 1; end
    end
  endtask

  task automatic load_page(input logic [15:0] a, input int n);
    reset_seq();
    load_addr(a, 16);
    for (int i = 0; i < n; i++)
      for (int k = 7; k >= 0; k--) wr_bit(buf_d[i][k]);
  endtask

  task automatic start_nv(input bit expect_run, input string req);
    logic b;
    rd_bit(b); wr_bit(1'b1); rd_bit(b);
    rd_bit(b);
    chk(b == !expect_run, req, b, !expect_run);
    if (expect_run) begin
      int n = 1;
      while (b == 0 && n < 60) begin rd_bit(b); n++; end
      chk(b == 1 && n > 1, req, b, 1);
    end
  endtask

  task automatic check_range(input logic [15:0] a, input int n, input string req);
    logic [7:0] v;
    reset_seq();
    load_addr(a, 16);
    for (int i = 0; i < n; i++) begin
      logic [15:0] ad;
      ad = {a[15:8], 8'(a[7:0] + i)};
      read_byte(v);
      if (known(ad)) chk(v == exp_byte(ad), req, v, exp_byte(ad));
    end
    chk(idle == 0, "R5", idle, 0);
    wr_bit(1'b1);
    chk(idle == 1, "R5", idle, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", ntest, nfail);
      $finish;
    end
  end

  initial begin
    logic b;
    logic [7:0] v;
    void'($urandom(32'd7321));
    for (int i = 0; i < 256; i++) kn[i] = 0;
    repeat (5) @(negedge clk);
    rst = 0;
    repeat (3) @(negedge clk);

    chk(idle == 1, "R1", idle, 1);
    chk(dq_en == 0, "R1", dq_en, 0);
    rd_bit(b);
    chk(b == 1, "R1", b, 1);
    chk(last_en == 1, "R2", last_en, 1);

    reset_seq();
    chk(idle == 0, "R3", idle, 0);
    rd_bit(b);
    chk(b == 1, "R3", b, 1);
    reset_seq();
    load_addr(16'h0000, 10);
    chk(last_wen == 0, "R2", last_wen, 0);

    for (int i = 0; i < 32; i++) buf_d[i] = 8'(i * 7 + 3);
    load_page(16'h0000, 32);
    start_nv(1, "R6");
    apply_page(16'h0000, 32);
    for (int i = 0; i < 32; i++) buf_d[i] = 8'(~(i * 5));
    load_page(16'h00E0, 32);
    start_nv(1, "R6");
    apply_page(16'h00E0, 32);
    check_range(16'h0000, 3, "R6");
    check_range(16'h00FE, 4, "R4");

    for (int i = 0; i < 34; i++) buf_d[i] = 8'($urandom);
    load_page(16'h003E, 34);
    start_nv(1, "R7");
    apply_page(16'h003E, 34);
    check_range(16'h0020, 32, "R7");

    wp_n = 0;
    for (int i = 0; i < 4; i++) buf_d[i] = 8'hA5;
    load_page(16'h0000, 4);
    start_nv(0, "R8");
    wp_n = 1;
    check_range(16'h0000, 4, "R8");

    for (int i = 0; i < 8; i++) buf_d[i] = 8'(8'h30 + i);
    load_page(16'h0060, 8);
    rd_bit(b); wr_bit(1'b1); rd_bit(b);
    wp_n = 0;
    rd_bit(b);
    chk(b == 0, "R8", b, 0);
    begin
      int n = 1;
      while (b == 0 && n < 60) begin rd_bit(b); n++; end
    end
    wp_n = 1;
    apply_page(16'h0060, 8);
    check_range(16'h0060, 8, "R8");

    buf_d[0] = 8'h11;
    load_page(16'h0000, 1);
    wr_bit(1'b1); wr_bit(1'b0); wr_bit(1'b1);
    start_nv(0, "R9");
    check_range(16'h0000, 2, "R9");

    buf_d[0] = 8'h22; buf_d[1] = 8'h33;
    load_page(16'h0000, 2);
    rd_bit(b); rd_bit(b); wr_bit(1'b1); rd_bit(b);
    rd_bit(b);
    chk(b == 1, "R12", b, 1);
    chk(idle == 1, "R12", idle, 1);
    check_range(16'h0000, 2, "R12");

    reset_seq();
    load_addr(16'h1234, 8);
    rd_bit(b); wr_bit(1'b0); wr_bit(1'b0);
    chk(idle == 1, "R10", idle, 1);
    reset_seq();
    load_addr(16'h1234, 5);
    rd_bit(b); wr_bit(1'b1);
    chk(idle == 1, "R10", idle, 1);
    rd_bit(b);
    chk(b == 1, "R10", b, 1);

    check_range(16'h4001, 2, "R11");
    for (int i = 0; i < 3; i++) buf_d[i] = 8'hC3;
    load_page(16'h0105, 3);
    start_nv(1, "R11");
    check_range(16'h0005, 1, "R11");

    for (int it = 0; it < 6; it++) begin
      logic [15:0] a;
      int n;
      a = {8'h00, 3'($urandom % 8), 5'($urandom % 32)};
      n = 1 + int'($urandom % 32);
      for (int i = 0; i < n; i++) buf_d[i] = 8'($urandom);
      load_page(a, n);
      start_nv(1, "R9");
      apply_page(a, n);
      check_range({a[15:5], 5'd0}, 32, "R9");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end
endmodule